// File: doc/BRIEF.md
# Write Data Parity Poisoning Path

This block sits on the write-data path into memory. Each accepted beat carries eight data bytes and one parity bit per byte. The block checks every byte against its parity bit and then decides which parity goes to memory with the data. A mode bit in a 32-bit control register chooses the policy for a byte whose parity was wrong. In the regenerate policy, the byte is stored with newly computed correct parity. In the poison policy, the byte is stored with deliberately wrong parity, so that a later reader of that location also sees the corruption.

A detected error flags the outgoing beat. It raises a one-cycle interrupt request when the interrupt is enabled and not masked. A one-shot test hook corrupts the incoming parity of the next accepted beat. This lets both policies and the interrupt path be exercised without a faulty source. The path has a single register stage.

Top module: `wr_parity_poison`

## Requirements
- R1: The control register is 32 bits wide. Bit 18 is the poison-mode bit (1 = poison, 0 = regenerate) and is the only writable bit. The register resets to 0 and reads back with every other bit at 0. A write takes effect for beats accepted in the cycle after the write.
- R2: A beat accepted with `in_valid` high appears on `out_valid`/`out_data` exactly one clock later, with the data unchanged. `out_valid` is low in every other cycle.
- R3: Parity is even per byte lane. Lane i is `in_data[8i+7:8i]` together with `in_par[i]`. The lane is in error when the XOR of its eight data bits and its parity bit is 1. `out_perr` is high alongside an output beat that has at least one lane in error, and low otherwise.
- R4: In regenerate mode, `out_par[i]` is the XOR of the eight bits of lane i, whether or not that lane was in error.
- R5: In poison mode, `out_par[i]` is the correct parity of lane i, inverted for each lane in error. A lane without error carries correct parity.
- R6: `irq` is high in the same cycle as the output beat exactly when `out_perr` is high, `irq_en` was 1 and `irq_mask` was 0 when the beat was accepted.
- R7: A pulse on `inj_arm` inverts all eight incoming parity bits of the next beat accepted in a later cycle. The inversion is applied before the check, and it works in both modes. Cycles without a valid beat leave the injection pending. The beat that uses it clears it, unless `inj_arm` is high again in that same cycle.
- R8: When an injection meets a beat whose lane already had a wrong parity bit, the two inversions cancel in that lane. That lane is then treated as error-free, while the other lanes show the injected error.
- R9: After reset, `out_valid`, `out_perr` and `irq` are 0 and no injection is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 32 | Control register write data |
| cfg_rdata | output | 32 | Control register read value |
| irq_en | input | 1 | Interrupt enable |
| irq_mask | input | 1 | Interrupt mask (1 suppresses) |
| inj_arm | input | 1 | Arms a one-shot parity inversion |
| in_valid | input | 1 | Input beat valid |
| in_data | input | 64 | Input data beat |
| in_par | input | 8 | Input per-lane parity |
| out_valid | output | 1 | Output beat valid |
| out_data | output | 64 | Output data to memory |
| out_par | output | 8 | Output per-lane parity to memory |
| out_perr | output | 1 | Parity error seen on this beat |
| irq | output | 1 | Error interrupt request |

## Verification
Two functions can land on the same beat: an armed injection and a parity error already present in the incoming data. The bench provokes this by arming an injection and then sending a beat with one wrong parity bit. In the poison policy, it checks that the stored parity of the faulty lane comes out correct, while all other lanes come out inverted. A second collision is a re-arm in the same cycle as the consuming beat. It is judged by checking that the following beat is still corrupted.

// File: rtl/pp_pkg.sv
package pp_pkg;
    localparam int LANES   = 8;
    localparam int LANE_W  = 8;
    localparam int DATA_W  = LANES * LANE_W;
    localparam int CFG_W   = 32;
    localparam int POISON_BIT = 18;

    typedef logic [LANE_W-1:0] lane_t;
    typedef logic [LANES-1:0]  lmask_t;

    typedef struct packed {
        logic               valid;
        logic [DATA_W-1:0]  data;
        lmask_t             par;
        logic               perr;
        logic               irq;
    } beat_t;

    typedef enum logic {POL_REGEN = 1'b0, POL_POISON = 1'b1} policy_e;

    function automatic logic even_par(input lane_t b);
        return ^b;
    endfunction
endpackage

// File: rtl/pp_lane_check.sv
module pp_lane_check
    import pp_pkg::*;
(
    input  lane_t data_i,
    input  logic  par_i,
    input  logic  inv_i,
    output logic  gen_o,
    output logic  err_o
);
    logic eff_par;

    always_comb begin
        eff_par = par_i ^ inv_i;
        gen_o   = even_par(data_i);
        err_o   = gen_o ^ eff_par;
    end
endmodule

// File: rtl/pp_ctrl.sv
module pp_ctrl
    import pp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_rdata,
    input  logic             inj_arm,
    input  logic             beat_take,
    output policy_e          policy,
    output logic             inj_armed
);
    always_ff @(posedge clk) begin
        if (rst) begin
            policy    <= POL_REGEN;
            inj_armed <= 1'b0;
        end else begin
            if (cfg_we)
                policy <= policy_e'(cfg_wdata[POISON_BIT]);
            if (inj_arm)
                inj_armed <= 1'b1;
            else if (beat_take)
                inj_armed <= 1'b0;
        end
    end

    always_comb begin
        cfg_rdata             = '0;
        cfg_rdata[POISON_BIT] = policy;
    end
endmodule

// File: rtl/wr_parity_poison.sv
module wr_parity_poison
    import pp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [CFG_W-1:0]  cfg_rdata,
    input  logic              irq_en,
    input  logic              irq_mask,
    input  logic              inj_arm,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic [LANES-1:0]  in_par,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic [LANES-1:0]  out_par,
    output logic              out_perr,
    output logic              irq
);
    policy_e policy;
    logic    inj_armed;
    lmask_t  gen, err;
    beat_t   nxt, stage;

    pp_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .inj_arm   (inj_arm),
        .beat_take (in_valid),
        .policy    (policy),
        .inj_armed (inj_armed)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        pp_lane_check u_chk (
            .data_i (in_data[i*LANE_W +: LANE_W]),
            .par_i  (in_par[i]),
            .inv_i  (inj_armed),
            .gen_o  (gen[i]),
            .err_o  (err[i])
        );
    end

    always_comb begin
        nxt.valid = in_valid;
        nxt.data  = in_data;
        nxt.par   = (policy == POL_POISON) ? (gen ^ err) : gen;
        nxt.perr  = in_valid && (|err);
        nxt.irq   = nxt.perr && irq_en && !irq_mask;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage <= '0;
        end else begin
            stage.valid <= nxt.valid;
            stage.perr  <= nxt.perr;
            stage.irq   <= nxt.irq;
            if (in_valid) begin
                stage.data <= nxt.data;
                stage.par  <= nxt.par;
            end
        end
    end

    assign out_valid = stage.valid;
    assign out_data  = stage.data;
    assign out_par   = stage.par;
    assign out_perr  = stage.perr;
    assign irq       = stage.irq;
endmodule

// File: rtl/pp_checker.sv
module pp_checker
    import pp_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [CFG_W-1:0]  cfg_rdata,
    input logic              in_valid,
    input logic              inj_arm,
    input logic              inj_armed,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data,
    input logic [LANES-1:0]  out_par,
    input logic              out_perr,
    input logic              irq
);
    logic seen_clk;
    always_ff @(posedge clk) seen_clk <= 1'b1;

    assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (rst)
        seen_clk |-> ((cfg_rdata & ~(32'd1 << POISON_BIT)) == '0));

    assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
        seen_clk && !$past(rst) |-> out_valid == $past(in_valid));

    assert_perr_gated_R3: assert property (@(posedge clk) disable iff (rst)
        out_perr |-> out_valid);

    assert_regen_even_R4: assert property (@(posedge clk) disable iff (rst)
        seen_clk && !$past(rst) && out_valid && !$past(cfg_rdata[POISON_BIT])
        |-> ^{out_data, out_par} == 1'b0);

    assert_irq_needs_err_R6: assert property (@(posedge clk) disable iff (rst)
        irq |-> out_perr);

    assert_inject_clears_R7: assert property (@(posedge clk) disable iff (rst)
        in_valid && !inj_arm |=> !inj_armed);

    assert_reset_state_R9: assert property (@(posedge clk)
        seen_clk && $past(rst) |-> !out_valid && !irq && !inj_armed);
endmodule

bind wr_parity_poison pp_checker u_pp_checker (
    .clk       (clk),
    .rst       (rst),
    .cfg_rdata (cfg_rdata),
    .in_valid  (in_valid),
    .inj_arm   (inj_arm),
    .inj_armed (inj_armed),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_par   (out_par),
    .out_perr  (out_perr),
    .irq       (irq)
);

// File: tb/tb_wr_parity_poison.sv
module tb_wr_parity_poison;
    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [31:0] cfg_wdata, cfg_rdata;
    logic        irq_en, irq_mask, inj_arm, in_valid;
    logic [63:0] in_data, out_data;
    logic [7:0]  in_par, out_par;
    logic        out_valid, out_perr, irq;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    int seed   = 32'h1234abcd;

    logic m_poison;
    logic m_armed;

    always #10 clk = ~clk;

    wr_parity_poison dut (.*);

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    function automatic logic [7:0] gen_par(input logic [63:0] d);
        logic [7:0] p;
        for (int i = 0; i < 8; i++) p[i] = ^d[i*8 +: 8];
        return p;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // drive one cycle at negedge, check outputs at following negedge
    task automatic step(input logic v, input logic [63:0] d, input logic [7:0] p,
                        input logic arm, input logic en, input logic msk,
                        input logic we, input logic pw);
        logic [7:0] ep, g, e, xp;
        logic       xperr, xirq;
        in_valid = v; in_data = d; in_par = p; inj_arm = arm;
        irq_en = en; irq_mask = msk; cfg_we = we;
        cfg_wdata = pw ? (32'd1 << 18) : 32'd0;
        ep    = p ^ {8{m_armed}};
        g     = gen_par(d);
        e     = g ^ ep;
        xp    = m_poison ? (g ^ e) : g;
        xperr = v && (e != 0);
        xirq  = xperr && en && !msk;
        if (arm) m_armed = 1'b1; else if (v) m_armed = 1'b0;
        if (we) m_poison = pw;
        @(negedge clk);
        chk("R2 valid", 64'(out_valid), 64'(v));
        chk("R3 perr", 64'(out_perr), 64'(xperr));
        chk("R6 irq", 64'(irq), 64'(xirq));
        if (v) begin
            chk("R2 data", out_data, d);
            chk(m_poison ? "R5 par" : "R4 par", 64'(out_par), 64'(xp));
        end
    endtask

    initial begin
        logic [63:0] d;
        logic [7:0]  g;
        in_valid = 0; in_data = 0; in_par = 0; inj_arm = 0;
        irq_en = 0; irq_mask = 0; cfg_we = 0; cfg_wdata = 0;
        m_poison = 0; m_armed = 0;
        rst = 1;
        @(negedge clk); @(negedge clk);
        rst = 0;
        // R9 reset state, R1 reset value
        chk("R9 out_valid", 64'(out_valid), 0);
        chk("R9 irq", 64'(irq), 0);
        chk("R1 reset", 64'(cfg_rdata), 0);

        // R4 regen: clean beat and error in lane 3
        d = 64'h0123456789abcdef;
        step(1, d, gen_par(d), 0, 1, 0, 0, 0);
        step(1, d, gen_par(d) ^ 8'h08, 0, 1, 0, 0, 0);
        // R6 masked / disabled
        step(1, d, gen_par(d) ^ 8'h01, 0, 1, 1, 0, 0);
        step(1, d, gen_par(d) ^ 8'h01, 0, 0, 0, 0, 0);

        // R1 write poison: all-ones written, only bit 18 sticks
        cfg_wdata = 32'hffffffff; cfg_we = 1; in_valid = 0; inj_arm = 0;
        m_poison = 1;
        @(negedge clk);
        cfg_we = 0;
        chk("R1 readback", 64'(cfg_rdata), 64'h40000);

        // R5 poison: errors in lanes 0 and 7
        step(1, d, gen_par(d) ^ 8'h81, 0, 1, 0, 0, 0);
        // R1 mode write in same cycle as beat: beat uses old (poison)
        step(1, d, gen_par(d) ^ 8'h02, 0, 1, 0, 1, 0);
        step(1, d, gen_par(d) ^ 8'h02, 0, 1, 0, 0, 0);

        // R7 inject in regen mode, with idle gaps between arm and use
        step(0, 0, 0, 1, 1, 0, 0, 0);
        step(0, 0, 0, 0, 1, 0, 0, 0);
        step(1, d, gen_par(d), 0, 1, 0, 0, 0);
        step(1, d, gen_par(d), 0, 1, 0, 0, 0); // cleared: clean

        // R8 inject in poison mode on beat with lane 2 already wrong
        step(0, 0, 0, 0, 1, 0, 1, 1);
        step(0, 0, 0, 1, 1, 0, 0, 0);
        g = gen_par(d);
        step(1, d, g ^ 8'h04, 0, 1, 0, 0, 0);
        chk("R8 cancel lane", 64'(out_par), 64'(g ^ 8'hfb));

        // R7 re-arm in consuming cycle keeps injection pending
        step(0, 0, 0, 1, 1, 0, 0, 0);
        step(1, d, g, 1, 1, 0, 0, 0);
        step(1, d, g, 0, 1, 0, 0, 0);
        chk("R7 rearm perr", 64'(out_perr), 1);
        step(1, d, g, 0, 1, 0, 0, 0);

        // random mix
        for (int n = 0; n < 400; n++) begin
            logic [63:0] rd;
            logic [7:0]  rp;
            rd = {$urandom(seed), $urandom()};
            rp = gen_par(rd) ^ (($urandom() % 3 == 0) ? 8'($urandom()) : 8'h00);
            step(1'($urandom() % 4 != 0), rd, rp, 1'($urandom() % 8 == 0),
                 1'($urandom() % 2), 1'($urandom() % 4 == 0),
                 1'($urandom() % 16 == 0), 1'($urandom() % 2));
        end

        // R9 reset clears a pending injection
        step(0, 0, 0, 1, 1, 0, 0, 0);
        rst = 1; in_valid = 0; inj_arm = 0;
        @(negedge clk);
        rst = 0; m_armed = 0; m_poison = 0;
        step(1, d, gen_par(d), 0, 1, 0, 0, 0);
        chk("R9 no pending inject", 64'(out_perr), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule